// File: doc/BRIEF.md
# Early-Output Dual-Rail AND Stage

This block computes the logical AND of two operands that arrive as dual-rail codes in a four-phase, return-to-zero handshake pipeline. Each operand uses two wires: `00` is the empty (spacer) state, `01` is a logic zero and `10` is a logic one. The block does not wait for both operands before it produces a result. A single zero operand already decides the AND, so the result goes out at once and the downstream stage can start work while the other operand is still on its way.

A completion path runs beside the early result. It raises a validity flag only after every operand has arrived. It acknowledges the producers only after both the result and that flag are set, so no operand is acknowledged before it has actually been seen. On the return phase, the result goes back to the spacer only after both operands are empty and the consumer has acknowledged. The validity flag and the upstream acknowledges then fall in turn.

State-holding completion elements are modelled as C-elements: registered cells on a sampling clock that rise when all their inputs are high, fall when all are low, and otherwise hold. A synchronous active-high reset clears the whole stage.

Top module: `eoand_stage`

## Requirements
- R1: The result rails `y_rail` never carry the code `11`. Only `00` (empty), `01` (zero) and `10` (one) appear.
- R2: When the result is empty and `y_ack` is low, an operand holding `01` (zero) makes `y_rail` read `01` on the next clock edge, whatever the other operand holds.
- R3: `y_rail` becomes `10` (one) only on the edge after both operands held `10`. A single `10` operand with the other operand empty leaves `y_rail` at `00`.
- R4: Once `y_rail` holds a non-empty code, it keeps that code unchanged until it returns to `00`. An operand that arrives later does not alter it.
- R5: `y_valid` rises only on an edge where both operands were non-empty, and it stays low while either operand is still empty.
- R6: `a_ack` and `b_ack` are equal. They rise only on an edge where `y_valid` was already high and `y_rail` was non-empty, and they stay low while an operand is missing.
- R7: `y_rail` returns to `00` only on the edge after both operands were `00` and `y_ack` was high. While `y_ack` stays low, the result is held even after the operands have gone empty.
- R8: After the result has returned to `00` with both operands empty, `y_valid` falls on the next edge, and `a_ack`/`b_ack` fall on the edge after that.
- R9: While `y_ack` is high, an empty result is not re-evaluated. New operand data is only taken up on the edge after `y_ack` has gone low.
- R10: A synchronous active-high `rst` sets `y_rail` to `00` and drives `y_valid`, `a_ack` and `b_ack` low on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock for the completion elements |
| rst | input | 1 | Synchronous active-high reset |
| a_rail | input | 2 | Operand A, dual-rail (`00` empty, `01` zero, `10` one) |
| a_ack | output | 1 | Acknowledge to the producer of operand A |
| b_rail | input | 2 | Operand B, dual-rail |
| b_ack | output | 1 | Acknowledge to the producer of operand B |
| y_rail | output | 2 | Dual-rail AND result |
| y_valid | output | 1 | High once every operand has arrived |
| y_ack | input | 1 | Acknowledge from the consumer of the result |

## Verification
The bench feeds each operand ordering with every zero/one combination. After the first operand only, it checks that a zero gives an immediate result while a lone one gives nothing. A design that waited for both operands would miss the early zero, and one that decided on a single one would emit a wrong result. It then holds operands away to confirm that the validity flag and the acknowledges wait, because an early acknowledge would let a producer drop data it never delivered. It also checks that a late second operand cannot overwrite an early zero. In the return phase, it holds back the consumer acknowledge to confirm that the result is kept. Raising that acknowledge early shows whether a stage that re-evaluates too soon would start a fresh token mid-handshake. A reset in the middle of a transfer closes the run.

// File: rtl/eoand_pkg.sv
package eoand_pkg;

    localparam int RAIL_W = 2;

    typedef enum logic [RAIL_W-1:0] {
        DR_EMPTY = 2'b00,
        DR_ZERO  = 2'b01,
        DR_ONE   = 2'b10,
        DR_BAD   = 2'b11
    } dr_code_t;

    typedef struct packed {
        logic     fire;
        dr_code_t code;
    } eval_res_t;

    function automatic logic dr_present(input logic [RAIL_W-1:0] c);
        return (c == DR_ZERO) || (c == DR_ONE);
    endfunction

    function automatic logic dr_is_zero(input logic [RAIL_W-1:0] c);
        return c == DR_ZERO;
    endfunction

    function automatic logic dr_is_one(input logic [RAIL_W-1:0] c);
        return c == DR_ONE;
    endfunction

endpackage

// File: rtl/eoand_celem.sv
module eoand_celem #(
    parameter int N_IN = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N_IN-1:0] in_bits,
    output logic            q
);
    logic all_hi;
    logic all_lo;

    assign all_hi = &in_bits;
    assign all_lo = ~(|in_bits);

    // Rendezvous cell: rise on unanimous high, fall on unanimous low, else hold.
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= 1'b0;
        end else if (all_hi) begin
            q <= 1'b1;
        end else if (all_lo) begin
            q <= 1'b0;
        end
    end
endmodule

// File: rtl/eoand_eval.sv
module eoand_eval
    import eoand_pkg::*;
#(
    parameter int N_OPS = 2,
    localparam int BUS_W = N_OPS * RAIL_W
) (
    input  logic [BUS_W-1:0] ops,
    output eval_res_t        res,
    output logic [N_OPS-1:0] present,
    output logic             all_empty
);
    logic [N_OPS-1:0] is_zero;
    logic [N_OPS-1:0] is_one;

    for (genvar g = 0; g < N_OPS; g++) begin : g_op
        logic [RAIL_W-1:0] c;
        assign c          = ops[g*RAIL_W +: RAIL_W];
        assign is_zero[g] = dr_is_zero(c);
        assign is_one[g]  = dr_is_one(c);
        assign present[g] = dr_present(c);
    end

    assign all_empty = ~(|present);

    // A zero on any operand decides the AND; a one needs every operand.
    always_comb begin
        res.fire = 1'b0;
        res.code = DR_EMPTY;
        if (|is_zero) begin
            res.fire = 1'b1;
            res.code = DR_ZERO;
        end else if (&is_one) begin
            res.fire = 1'b1;
            res.code = DR_ONE;
        end
    end
endmodule

// File: rtl/eoand_rail.sv
module eoand_rail
    import eoand_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  eval_res_t res,
    input  logic      ops_empty,
    input  logic      dn_ack,
    output dr_code_t  y
);
    always_ff @(posedge clk) begin
        if (rst) begin
            y <= DR_EMPTY;
        end else if (y == DR_EMPTY) begin
            if (!dn_ack && res.fire) begin
                y <= res.code;
            end
        end else if (ops_empty && dn_ack) begin
            y <= DR_EMPTY;
        end
    end
endmodule

// File: rtl/eoand_stage.sv
module eoand_stage
    import eoand_pkg::*;
#(
    parameter int N_OPS = 2,
    localparam int BUS_W = N_OPS * RAIL_W
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] a_rail,
    output logic       a_ack,
    input  logic [1:0] b_rail,
    output logic       b_ack,
    output logic [1:0] y_rail,
    output logic       y_valid,
    input  logic       y_ack
);
    logic [BUS_W-1:0] ops;
    eval_res_t        res;
    logic [N_OPS-1:0] present;
    logic             ops_empty;
    dr_code_t         y_q;
    logic             y_present;
    logic             valid_q;
    logic             ack_q;

    assign ops = {b_rail, a_rail};

    eoand_eval #(.N_OPS(N_OPS)) u_eval (
        .ops       (ops),
        .res       (res),
        .present   (present),
        .all_empty (ops_empty)
    );

    eoand_rail u_rail (
        .clk       (clk),
        .rst       (rst),
        .res       (res),
        .ops_empty (ops_empty),
        .dn_ack    (y_ack),
        .y         (y_q)
    );

    assign y_present = dr_present(y_q);

    // Validity joins every operand's arrival with the presence of the result.
    eoand_celem #(.N_IN(N_OPS + 1)) u_valid (
        .clk     (clk),
        .rst     (rst),
        .in_bits ({y_present, present}),
        .q       (valid_q)
    );

    // Upstream acknowledge joins the result with its validity.
    eoand_celem #(.N_IN(2)) u_ack (
        .clk     (clk),
        .rst     (rst),
        .in_bits ({y_present, valid_q}),
        .q       (ack_q)
    );

    assign y_rail  = y_q;
    assign y_valid = valid_q;
    assign a_ack   = ack_q;
    assign b_ack   = ack_q;
endmodule

// File: rtl/eoand_stage_chk.sv
module eoand_stage_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] a_rail,
    input logic       a_ack,
    input logic [1:0] b_rail,
    input logic       b_ack,
    input logic [1:0] y_rail,
    input logic       y_valid,
    input logic       y_ack
);
    // R1
    no_bad_code_chk: assert property (@(posedge clk) disable iff (rst)
        y_rail != 2'b11);

    // R2
    early_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (y_rail == 2'b00 && !y_ack && (a_rail == 2'b01 || b_rail == 2'b01))
        |=> y_rail == 2'b01);

    // R3
    one_needs_both_chk: assert property (@(posedge clk) disable iff (rst)
        (y_rail == 2'b10 && $past(y_rail) == 2'b00)
        |-> ($past(a_rail) == 2'b10 && $past(b_rail) == 2'b10));

    // R4
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(y_rail) != 2'b00 && y_rail != 2'b00) |-> $stable(y_rail));

    // R5
    valid_waits_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(y_valid) |-> ($past(a_rail) != 2'b00 && $past(b_rail) != 2'b00));

    // R6
    ack_after_valid_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(a_ack) |-> ($past(y_valid) && $past(y_rail) != 2'b00));

    // R6
    ack_pair_chk: assert property (@(posedge clk) disable iff (rst)
        a_ack == b_ack);

    // R7
    rtz_gate_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(y_rail) != 2'b00 && y_rail == 2'b00)
        |-> ($past(y_ack) && $past(a_rail) == 2'b00 && $past(b_rail) == 2'b00));

    // R9
    no_refire_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(y_rail) == 2'b00 && y_rail != 2'b00) |-> !$past(y_ack));

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (y_rail == 2'b00 && !y_valid && !a_ack && !b_ack));
endmodule

bind eoand_stage eoand_stage_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .a_rail  (a_rail),
    .a_ack   (a_ack),
    .b_rail  (b_rail),
    .b_ack   (b_ack),
    .y_rail  (y_rail),
    .y_valid (y_valid),
    .y_ack   (y_ack)
);

// File: tb/test_eoand_stage.sv
`timescale 1ns/1ps
module test_eoand_stage;
    localparam logic [1:0] E = 2'b00;
    localparam logic [1:0] Z = 2'b01;
    localparam logic [1:0] O = 2'b10;
    localparam int NV = 8;
    // {a_first, a, b, early y, final y}
    localparam logic [8:0] VEC [NV] = '{
        {1'b1, Z, Z, Z, Z},
        {1'b1, Z, O, Z, Z},
        {1'b1, O, Z, E, Z},
        {1'b1, O, O, E, O},
        {1'b0, Z, Z, Z, Z},
        {1'b0, O, Z, Z, Z},
        {1'b0, Z, O, E, Z},
        {1'b0, O, O, E, O}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] a_rail = E;
    logic [1:0] b_rail = E;
    logic       y_ack = 1'b0;
    logic       a_ack, b_ack, y_valid;
    logic [1:0] y_rail;
    int         n_chk = 0;
    int         n_bad = 0;
    int         bad_code = 0;
    bit         done = 0;

    always #2.5 clk = ~clk;

    eoand_stage i_eoand_stage (
        .clk(clk), .rst(rst),
        .a_rail(a_rail), .a_ack(a_ack),
        .b_rail(b_rail), .b_ack(b_ack),
        .y_rail(y_rail), .y_valid(y_valid), .y_ack(y_ack)
    );

    always @(negedge clk)
        if (!rst && (y_rail == 2'b11 || a_rail == 2'b11 || b_rail == 2'b11))
            bad_code++;

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic outs(input string req, input logic [1:0] y, input logic v, input logic k);
        chk(req, {y_rail, y_valid, a_ack}, {y, v, k});
        chk({req, " ack pair"}, {3'b0, b_ack}, {3'b0, a_ack});
    endtask

    task automatic run_vec(input logic [8:0] v);
        logic af = v[8];
        logic [1:0] av = v[7:6], bv = v[5:4], ey = v[3:2], fy = v[1:0];
        if (af) a_rail = av; else b_rail = bv;
        step(1);
        chk("R2/R3 early result", {2'b0, y_rail}, {2'b0, ey});
        step(2);
        chk("R5/R6 wait for missing operand", {2'b0, y_valid, a_ack}, 4'b0);
        if (af) b_rail = bv; else a_rail = av;
        step(1);
        chk("R3/R4 final result", {2'b0, y_rail}, {2'b0, fy});
        step(2);
        outs("R5/R6 valid and ack up", fy, 1'b1, 1'b1);
        a_rail = E; b_rail = E;
        step(3);
        outs("R7 result held until y_ack", fy, 1'b1, 1'b1);
        y_ack = 1'b1;
        step(1);
        chk("R7 return to empty", {2'b0, y_rail}, {2'b0, E});
        step(1);
        chk("R8 valid falls", {3'b0, y_valid}, 4'b0);
        step(1);
        outs("R8 ack falls", E, 1'b0, 1'b0);
        y_ack = 1'b0;
        step(1);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        step(3);
        outs("R10 reset state", E, 1'b0, 1'b0);
        rst = 1'b0;
        step(1);

        for (int i = 0; i < NV; i++) run_vec(VEC[i]);

        // R9: y_ack still high blocks a new evaluation
        y_ack = 1'b1;
        a_rail = Z;
        step(2);
        chk("R9 no evaluation under y_ack", {2'b0, y_rail}, {2'b0, E});
        y_ack = 1'b0;
        step(1);
        chk("R9 evaluation after y_ack low", {2'b0, y_rail}, {2'b0, Z});
        b_rail = O;
        step(3);
        outs("R4 late one keeps zero", Z, 1'b1, 1'b1);

        // R10: reset in mid-transfer
        rst = 1'b1;
        step(1);
        outs("R10 mid-transfer reset", E, 1'b0, 1'b0);
        a_rail = E; b_rail = E;
        step(1);
        rst = 1'b0;
        step(2);
        outs("R10 idle after reset", E, 1'b0, 1'b0);

        chk("R1 no 11 code seen", 4'(bad_code > 0), 4'b0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule